// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block holds chip-level configuration words behind a small word-wide register interface with an address, write data, a write strobe and a combinational read port. Two kinds of protection guard the configuration words. Each of the `NLOCK` guarded words has a private lock register that opens when its own 32-bit key is written there. A selectable subset of these locks closes again by itself a fixed number of cycles after opening. The remaining `NKCFG` words sit behind a shared pair of kick registers, and both of them must hold their keys at the same time before a write gets through.

A write to a guarded word while its protection is engaged is dropped. The word keeps its value, and a sticky flag for that word is raised in a violation register, which software clears by writing ones. Lock and kick registers read back only an open bit, never the key. All configuration values are also driven out in parallel as flat buses for the rest of the chip.

Each lock runs its own state machine with three states. `LK_SHUT` is locked. `LK_TIMED` is open with a relock countdown. `LK_HELD` is open until the lock register is written again. Transitions:
- key-match: from any state to `LK_TIMED` (auto-relock channel) or `LK_HELD` (other channels).
- any other write to the lock register, including zero: to `LK_SHUT`.
- countdown expiry: `LK_TIMED` to `LK_SHUT`.

The kick unit has four states: `KK_SHUT`, `KK_FIRST` (only kick A holds its key), `KK_SECOND` (only kick B holds its key) and `KK_OPEN` (both hold their keys). On a write, each kick half becomes "holding" if its key was written and "not holding" otherwise. The state follows the resulting pair.

Top module: `cfg_lock_bank`

Word address map (defaults `NLOCK`=4, `NKCFG`=2):

| Address | Contents |
|---|---|
| 0..3 | guarded words |
| 4..7 | lock registers |
| 8 | kick A |
| 9 | kick B |
| 10..11 | kick-guarded words |
| 12 | violation flags |

Key of lock i is `LOCK_KEY_BASE + i`.

## Requirements
- R1: After reset, every configuration word, lock read-back, kick read-back and violation flag is zero.
- R2: Writing `LOCK_KEY_BASE + i` to lock register i opens lock i. Reading a lock register returns 1 in bit 0 when open and 0 when locked, with all other bits zero.
- R3: A write to guarded word i while lock i is open replaces its value, and the value is readable from the next cycle.
- R4: A write to guarded word i while lock i is locked leaves the word unchanged and sets violation bit i.
- R5: A lock whose `AUTO_MASK` bit is set accepts protected writes on the `RELOCK_CYCLES` clock edges that follow the key write, and relocks after that. A lock with its mask bit clear stays open indefinitely.
- R6: Writing zero to a lock register locks it from the next cycle, even inside an auto-relock window.
- R7: Writing a wrong nonzero key to a lock register leaves it locked, or locks it if it was open.
- R8: A write to kick-guarded word j is accepted only while both kick registers hold their keys. Otherwise it is dropped and violation bit `NLOCK + j` is set.
- R9: A kick register reads 1 in bit 0 while it holds its key. Writing zero to both kick registers restores protection.
- R10: Violation flags stay set until a write to the violation register with a 1 in the matching bit position. Zero bits in that write leave their flags unchanged.
- R11: Addresses above the violation register read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| cfg_out | output | NLOCK*DW | Lock-guarded words, word i at bits i*DW |
| kcfg_out | output | NKCFG*DW | Kick-guarded words, word j at bits j*DW |

## Verification
Every write takes effect at the clock edge on which it is presented. The read port is combinational, so a stored value, a lock or kick open bit, or a violation flag can be seen in the low phase right after that edge. The bench drives each write for exactly one edge and then reads back in the following low phase, before the next edge. The auto-relock window is counted in edges. The key write sits on edge P0, idle cycles are counted explicitly, and a protected write placed on edge P0+`RELOCK_CYCLES` must land while one placed on edge P0+`RELOCK_CYCLES`+1 must be dropped.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;

    typedef enum logic [1:0] {
        LK_SHUT  = 2'd0,
        LK_TIMED = 2'd1,
        LK_HELD  = 2'd2
    } lock_state_e;

    typedef enum logic [1:0] {
        KK_SHUT   = 2'd0,
        KK_FIRST  = 2'd1,
        KK_SECOND = 2'd2,
        KK_OPEN   = 2'd3
    } kick_state_e;

endpackage

// File: rtl/lock_channel.sv
module lock_channel
    import cfglock_pkg::*;
#(
    parameter int            DW            = 32,
    parameter logic [DW-1:0] KEY           = '0,
    parameter bit            AUTO          = 1'b0,
    parameter int            RELOCK_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_wr,
    input  logic [DW-1:0] wdata,
    output logic          is_open
);
    localparam int CW = $clog2(RELOCK_CYCLES + 1);

    lock_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_SHUT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (lock_wr) begin
            if (wdata == KEY) begin
                state_d = AUTO ? LK_TIMED : LK_HELD;
                cnt_d   = CW'(RELOCK_CYCLES);
            end else begin
                state_d = LK_SHUT;
            end
        end else begin
            unique case (state_q)
                LK_SHUT: ;
                LK_HELD: ;
                LK_TIMED: begin
                    if (cnt_q == CW'(1)) state_d = LK_SHUT;
                    else                 cnt_d   = cnt_q - CW'(1);
                end
                default: state_d = LK_SHUT;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_TIMED, LK_HELD: is_open = 1'b1;
            default:           is_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/kick_unit.sv
module kick_unit
    import cfglock_pkg::*;
#(
    parameter int            DW    = 32,
    parameter logic [DW-1:0] KEY_A = '0,
    parameter logic [DW-1:0] KEY_B = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [DW-1:0] wdata,
    output logic          a_ok,
    output logic          b_ok,
    output logic          both_ok
);
    kick_state_e state_q, state_d;
    logic a_now, b_now, a_nx, b_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KK_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        a_now = (state_q == KK_FIRST)  || (state_q == KK_OPEN);
        b_now = (state_q == KK_SECOND) || (state_q == KK_OPEN);
        a_nx  = wr_a ? (wdata == KEY_A) : a_now;
        b_nx  = wr_b ? (wdata == KEY_B) : b_now;
        unique case ({a_nx, b_nx})
            2'b11:   state_d = KK_OPEN;
            2'b10:   state_d = KK_FIRST;
            2'b01:   state_d = KK_SECOND;
            default: state_d = KK_SHUT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            KK_OPEN:   {a_ok, b_ok, both_ok} = 3'b111;
            KK_FIRST:  {a_ok, b_ok, both_ok} = 3'b100;
            KK_SECOND: {a_ok, b_ok, both_ok} = 3'b010;
            default:   {a_ok, b_ok, both_ok} = 3'b000;
        endcase
    end
endmodule

// File: rtl/guarded_reg.sv
module guarded_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_wr,
    input  logic          allow,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q,
    output logic          denied
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                q <= '0;
        else if (sel_wr && allow)  q <= wdata;
    end

    assign denied = sel_wr && !allow;
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
    import cfglock_pkg::*;
#(
    parameter int               DW            = 32,
    parameter int               ADDR_W        = 4,
    parameter int               NLOCK         = 4,
    parameter int               NKCFG         = 2,
    parameter int               RELOCK_CYCLES = 4,
    parameter logic [NLOCK-1:0] AUTO_MASK     = 4'b0011,
    parameter logic [DW-1:0]    LOCK_KEY_BASE = 32'h5EC0_0A00,
    parameter logic [DW-1:0]    KICK_KEY_A    = 32'h83E7_0F1D,
    parameter logic [DW-1:0]    KICK_KEY_B    = 32'h95A2_C4B6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    input  logic                  bus_we,
    output logic [DW-1:0]         bus_rdata,
    output logic [NLOCK*DW-1:0]   cfg_out,
    output logic [NKCFG*DW-1:0]   kcfg_out
);
    localparam int CFG_BASE  = 0;
    localparam int LOCK_BASE = CFG_BASE + NLOCK;
    localparam int KICK_BASE = LOCK_BASE + NLOCK;
    localparam int KCFG_BASE = KICK_BASE + 2;
    localparam int VIOL_ADDR = KCFG_BASE + NKCFG;
    localparam int NVIOL     = NLOCK + NKCFG;

    logic [NLOCK-1:0][DW-1:0] cfg_q;
    logic [NKCFG-1:0][DW-1:0] kcfg_q;
    logic [NLOCK-1:0]         lock_open;
    logic [NVIOL-1:0]         denied_vec;
    logic [NVIOL-1:0]         viol_q;
    logic [NVIOL-1:0]         viol_clr;
    logic                     kick_a_ok, kick_b_ok, kick_open;

    for (genvar i = 0; i < NLOCK; i++) begin : g_lock
        lock_channel #(
            .DW(DW), .KEY(LOCK_KEY_BASE + DW'(i)),
            .AUTO(AUTO_MASK[i]), .RELOCK_CYCLES(RELOCK_CYCLES)
        ) u_lock (
            .clk(clk), .rst_n(rst_n),
            .lock_wr(bus_we && bus_addr == ADDR_W'(LOCK_BASE + i)),
            .wdata(bus_wdata), .is_open(lock_open[i])
        );
        guarded_reg #(.DW(DW)) u_word (
            .clk(clk), .rst_n(rst_n),
            .sel_wr(bus_we && bus_addr == ADDR_W'(CFG_BASE + i)),
            .allow(lock_open[i]), .wdata(bus_wdata),
            .q(cfg_q[i]), .denied(denied_vec[i])
        );
    end

    kick_unit #(.DW(DW), .KEY_A(KICK_KEY_A), .KEY_B(KICK_KEY_B)) u_kick (
        .clk(clk), .rst_n(rst_n),
        .wr_a(bus_we && bus_addr == ADDR_W'(KICK_BASE)),
        .wr_b(bus_we && bus_addr == ADDR_W'(KICK_BASE + 1)),
        .wdata(bus_wdata),
        .a_ok(kick_a_ok), .b_ok(kick_b_ok), .both_ok(kick_open)
    );

    for (genvar j = 0; j < NKCFG; j++) begin : g_kcfg
        guarded_reg #(.DW(DW)) u_word (
            .clk(clk), .rst_n(rst_n),
            .sel_wr(bus_we && bus_addr == ADDR_W'(KCFG_BASE + j)),
            .allow(kick_open), .wdata(bus_wdata),
            .q(kcfg_q[j]), .denied(denied_vec[NLOCK + j])
        );
    end

    // sticky violation flags, write-one-to-clear
    assign viol_clr = (bus_we && bus_addr == ADDR_W'(VIOL_ADDR))
                    ? bus_wdata[NVIOL-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) viol_q <= '0;
        else        viol_q <= (viol_q & ~viol_clr) | denied_vec;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NLOCK; i++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + i))  bus_rdata = cfg_q[i];
            if (bus_addr == ADDR_W'(LOCK_BASE + i)) bus_rdata = DW'(lock_open[i]);
        end
        for (int j = 0; j < NKCFG; j++)
            if (bus_addr == ADDR_W'(KCFG_BASE + j)) bus_rdata = kcfg_q[j];
        if (bus_addr == ADDR_W'(KICK_BASE))     bus_rdata = DW'(kick_a_ok);
        if (bus_addr == ADDR_W'(KICK_BASE + 1)) bus_rdata = DW'(kick_b_ok);
        if (bus_addr == ADDR_W'(VIOL_ADDR))     bus_rdata = DW'(viol_q);
    end

    assign cfg_out  = cfg_q;
    assign kcfg_out = kcfg_q;
endmodule

// File: rtl/cfg_lock_bank_chk.sv
module cfg_lock_bank_chk #(
    parameter int               DW            = 32,
    parameter int               ADDR_W        = 4,
    parameter int               NLOCK         = 4,
    parameter int               NKCFG         = 2,
    parameter int               RELOCK_CYCLES = 4,
    parameter logic [NLOCK-1:0] AUTO_MASK     = 4'b0011,
    parameter logic [DW-1:0]    LOCK_KEY_BASE = 32'h5EC0_0A00
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [DW-1:0]           bus_wdata,
    input logic                    bus_we,
    input logic [DW-1:0]           bus_rdata,
    input logic [NLOCK*DW-1:0]     cfg_out,
    input logic [NKCFG*DW-1:0]     kcfg_out,
    input logic [NLOCK-1:0]        lock_open,
    input logic                    kick_open,
    input logic [NLOCK+NKCFG-1:0]  viol_q
);
    localparam int LOCK_BASE = NLOCK;
    localparam int KICK_BASE = 2 * NLOCK;
    localparam int KCFG_BASE = KICK_BASE + 2;
    localparam int VIOL_ADDR = KCFG_BASE + NKCFG;

    for (genvar i = 0; i < NLOCK; i++) begin : g_lk
        logic hit_cfg, hit_lock;
        int   win_cnt;
        assign hit_cfg  = bus_we && bus_addr == ADDR_W'(i);
        assign hit_lock = bus_we && bus_addr == ADDR_W'(LOCK_BASE + i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                              win_cnt <= 0;
            else if (hit_lock && bus_wdata == LOCK_KEY_BASE + DW'(i)) win_cnt <= 1;
            else if (lock_open[i] && win_cnt <= RELOCK_CYCLES)       win_cnt <= win_cnt + 1;
            else if (!lock_open[i])                                  win_cnt <= 0;
        end

        assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_cfg && !lock_open[i]) |=> $stable(cfg_out[i*DW +: DW]));
        assert_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_cfg && !lock_open[i]) |=> viol_q[i]);
        assert_zero_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_lock && bus_wdata == '0) |=> !lock_open[i]);
        assert_wrong_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_lock && bus_wdata != LOCK_KEY_BASE + DW'(i)) |=> !lock_open[i]);
        if (AUTO_MASK[i]) begin : g_auto
            assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
                lock_open[i] |-> (win_cnt >= 1 && win_cnt <= RELOCK_CYCLES));
        end
    end

    for (genvar j = 0; j < NKCFG; j++) begin : g_kk
        assert_kick_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(KCFG_BASE + j) && !kick_open)
            |=> $stable(kcfg_out[j*DW +: DW]));
    end

    assert_kick_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(KICK_BASE) && bus_wdata == '0) |=> !kick_open);

    assert_bit_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(LOCK_BASE) && bus_addr < ADDR_W'(KCFG_BASE))
        |-> bus_rdata[DW-1:1] == '0);

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_W'(VIOL_ADDR)) |-> bus_rdata == '0);
endmodule

bind cfg_lock_bank cfg_lock_bank_chk #(
    .DW(DW), .ADDR_W(ADDR_W), .NLOCK(NLOCK), .NKCFG(NKCFG),
    .RELOCK_CYCLES(RELOCK_CYCLES), .AUTO_MASK(AUTO_MASK),
    .LOCK_KEY_BASE(LOCK_KEY_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cfg_out(cfg_out),
    .kcfg_out(kcfg_out), .lock_open(lock_open), .kick_open(kick_open),
    .viol_q(viol_q)
);

// File: tb/tb_cfg_lock_bank.sv
module tb_cfg_lock_bank;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [4*DW-1:0] cfg_out;
    logic [2*DW-1:0] kcfg_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cfg_lock_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata),
        .cfg_out(cfg_out), .kcfg_out(kcfg_out)
    );

    localparam logic [31:0] K0 = 32'h5EC0_0A00, K1 = 32'h5EC0_0A01;
    localparam logic [31:0] K2 = 32'h5EC0_0A02, K3 = 32'h5EC0_0A03;
    localparam logic [31:0] KA = 32'h83E7_0F1D, KB = 32'h95A2_C4B6;

    typedef struct packed {
        logic        we;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  chk;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd2,  32'h1111_2222, 4'd2,  32'h0,          8'd4},  // R4 locked drop
        '{1'b0, 4'd0,  32'h0,         4'd12, 32'h4,          8'd4},  // R4 flag
        '{1'b1, 4'd6,  K2,            4'd6,  32'h1,          8'd2},  // R2 open read
        '{1'b1, 4'd2,  32'h1111_2222, 4'd2,  32'h1111_2222,  8'd3},  // R3 accepted
        '{1'b1, 4'd6,  32'h5EC0_0A05, 4'd6,  32'h0,          8'd7},  // R7 wrong key
        '{1'b1, 4'd2,  32'h0000_AAAA, 4'd2,  32'h1111_2222,  8'd7},  // R7 stays locked
        '{1'b1, 4'd7,  K3,            4'd7,  32'h1,          8'd2},  // R2
        '{1'b1, 4'd7,  32'h0,         4'd7,  32'h0,          8'd6},  // R6 zero relock
        '{1'b1, 4'd3,  32'h0000_0033, 4'd3,  32'h0,          8'd6},  // R6 drop after
        '{1'b1, 4'd8,  KA,            4'd8,  32'h1,          8'd9},  // R9 kick A
        '{1'b1, 4'd10, 32'h0000_0077, 4'd10, 32'h0,          8'd8},  // R8 one kick
        '{1'b1, 4'd9,  KB,            4'd9,  32'h1,          8'd9},  // R9 kick B
        '{1'b1, 4'd10, 32'h0000_0077, 4'd10, 32'h0000_0077,  8'd8},  // R8 both kicks
        '{1'b1, 4'd11, 32'h0000_0099, 4'd11, 32'h0000_0099,  8'd8},  // R8
        '{1'b1, 4'd8,  32'h0,         4'd8,  32'h0,          8'd9},  // R9 clear A
        '{1'b1, 4'd9,  32'h0,         4'd9,  32'h0,          8'd9},  // R9 clear B
        '{1'b1, 4'd11, 32'h0000_0055, 4'd11, 32'h0000_0099,  8'd9},  // R9 protected
        '{1'b0, 4'd0,  32'h0,         4'd12, 32'h0000_003C,  8'd10}, // R10 sticky
        '{1'b1, 4'd12, 32'h0000_0014, 4'd12, 32'h0000_0028,  8'd10}, // R10 w1c
        '{1'b1, 4'd13, 32'hFFFF_FFFF, 4'd13, 32'h0,          8'd11}  // R11 unmapped
    };

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input int req);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            failures++;
            $display("FAIL R%0d addr=%0d actual=%h expected=%h", req, a, bus_rdata, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state over the whole map
        for (int a = 0; a < 14; a++) chk(AW'(a), '0, 1);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].we) wr(VECS[v].addr, VECS[v].wdata);
            else            idle(1);
            chk(VECS[v].chk, VECS[v].exp, int'(VECS[v].req));
        end

        // R5 last edge inside the window is accepted
        wr(4'd4, K0);
        idle(3);
        wr(4'd0, 32'hCAFE_0001);
        chk(4'd0, 32'hCAFE_0001, 5);
        chk(4'd4, 32'h0, 5);
        // R5 one edge past the window is dropped
        wr(4'd4, K0);
        idle(4);
        wr(4'd0, 32'hBEEF_0002);
        chk(4'd0, 32'hCAFE_0001, 5);
        // R5 held channel stays open
        wr(4'd6, K2);
        idle(8);
        chk(4'd6, 32'h1, 5);
        // R6 zero inside a timed window
        wr(4'd5, K1);
        wr(4'd5, 32'h0);
        wr(4'd1, 32'h0000_0012);
        chk(4'd1, 32'h0, 6);
        chk(4'd5, 32'h0, 6);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk(4'd0, '0, 1);
        chk(4'd6, '0, 1);
        chk(4'd11, '0, 1);
        chk(4'd12, '0, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule